// File: doc/BRIEF.md
# Integer Vector Execution Stage with Scalar Broadcast

This block is the integer execution stage of a pipeline that runs scalar and vector work on the same lane array. Sixteen 32-bit lanes each apply the same integer operation to a pair of operands. Either operand may be a full 512-bit vector or a scalar. A scalar operand is taken from the low 32 bits of its bus and copied into every lane. This lets a single instruction combine a vector with a scalar.

An instruction whose result is a scalar runs in lane 0 only. Only that lane is enabled for writeback. A vector result enables lanes through a per-lane predicate. Opcodes of the floating-point class share the same encoding space. This stage does not execute them: it raises an error flag and enables no lanes. The result, the lane write mask and the 5-bit destination register index are registered together. They appear one cycle after the instruction is presented, with no stalls.

Top module: `vec_alu_stage`

## Requirements
- R1: With `in_a_scalar` (or `in_b_scalar`) high, every lane uses bits [31:0] of that operand bus. With the flag low, lane i uses bits [32*i+31:32*i].
- R2: Opcode encodings are 0 add, 1 subtract (a-b), 2 and, 3 or and 4 xor. Arithmetic wraps modulo 2^32.
- R3: Opcode 5 shifts left, 6 shifts right logically, and 7 writes 1 when a < b as signed 32-bit values and 0 otherwise. Shift amounts use only the low 5 bits of b.
- R4: With `in_scalar_result` high, the mask is 16'h0001 whatever `in_pred` holds. Lane 0 carries the result and lanes 1 to 15 read zero.
- R5: For a vector-result integer instruction, the mask equals `in_pred`. Every lane carries its result, including lanes whose predicate bit is clear.
- R6: Opcodes 8 to 15 form the floating-point class. For these, `out_fp_error` is 1, the mask is 0 and the result is all zeros.
- R7: `out_valid` equals `in_valid` of the previous cycle. Instructions may be issued on consecutive cycles.
- R8: A cycle with `in_valid` low produces, one cycle later, `out_valid` 0, mask 0, `out_fp_error` 0 and a zero result.
- R9: `out_dst` carries the 5-bit `in_dst` of the instruction that produced the result.
- R10: While reset is held, `out_valid`, `out_mask`, `out_fp_error`, `out_result` and `out_dst` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 4 | Opcode; bit 3 set selects the floating-point class |
| in_a | input | 512 | First operand bus, lane i in bits [32i+31:32i] |
| in_b | input | 512 | Second operand bus |
| in_a_scalar | input | 1 | Broadcast lane 0 of `in_a` to all lanes |
| in_b_scalar | input | 1 | Broadcast lane 0 of `in_b` to all lanes |
| in_scalar_result | input | 1 | Result is a scalar written from lane 0 |
| in_pred | input | 16 | Per-lane predicate for vector results |
| in_dst | input | 5 | Destination register index (32 registers) |
| out_valid | output | 1 | Result present |
| out_result | output | 512 | Per-lane results |
| out_mask | output | 16 | Lane write-enable mask |
| out_fp_error | output | 1 | Floating-point opcode rejected |
| out_dst | output | 5 | Destination index of the result |

## Verification
On every cycle, the assertions check the valid pipeline timing, the mask chosen for scalar, vector and floating-point instructions, and the quiet state of an idle cycle. They also check that a broadcast operand reaches every lane unchanged. The lane arithmetic itself is not checked by any assertion. The bench sweeps every opcode against all four scalar/vector operand forms and both result kinds, over several data patterns. It then compares every lane with values it computes itself. Only these scenarios show signed comparison at the sign boundary, the masking of shift amounts, and zeroed upper lanes on scalar results.

// File: rtl/vpu_pkg.sv
package vpu_pkg;
  localparam int LANE_W  = 32;
  localparam int SHAMT_W = $clog2(LANE_W);
  localparam int FP_BIT  = 3;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_SHL = 4'd5,
    OP_SHR = 4'd6,
    OP_SLT = 4'd7
  } vop_e;

  function automatic logic op_is_fp(input logic [3:0] op);
    return op[FP_BIT];
  endfunction

  function automatic logic [LANE_W-1:0] lane_op(input logic [3:0] op,
                                                input logic [LANE_W-1:0] a,
                                                input logic [LANE_W-1:0] b);
    logic [SHAMT_W-1:0] sh;
    logic [LANE_W-1:0]  r;
    sh = b[SHAMT_W-1:0];
    case (vop_e'(op))
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_SHL:  r = a << sh;
      OP_SHR:  r = a >> sh;
      OP_SLT:  r = {{(LANE_W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/vpu_operand_bcast.sv
module vpu_operand_bcast #(
  parameter int LANES = 16,
  parameter int LW    = vpu_pkg::LANE_W,
  localparam int BUS_W = LANES * LW
) (
  input  logic [BUS_W-1:0] bus_in,
  input  logic             use_scalar,
  output logic [BUS_W-1:0] bus_out
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign bus_out[i*LW +: LW] = use_scalar ? bus_in[LW-1:0] : bus_in[i*LW +: LW];
  end
endmodule

// File: rtl/vpu_lane.sv
module vpu_lane (
  input  logic [3:0]                  op,
  input  logic [vpu_pkg::LANE_W-1:0]  a,
  input  logic [vpu_pkg::LANE_W-1:0]  b,
  output logic [vpu_pkg::LANE_W-1:0]  r
);
  assign r = vpu_pkg::lane_op(op, a, b);
endmodule

// File: rtl/vpu_mask_gen.sv
module vpu_mask_gen #(
  parameter int LANES = 16
) (
  input  logic             valid,
  input  logic             is_fp,
  input  logic             scalar_result,
  input  logic [LANES-1:0] pred,
  output logic [LANES-1:0] mask,
  output logic             fp_error
);
  localparam logic [LANES-1:0] LANE0_ONLY = LANES'(1);

  always_comb begin
    if (!valid || is_fp)      mask = '0;
    else if (scalar_result)   mask = LANE0_ONLY;
    else                      mask = pred;
  end

  assign fp_error = valid && is_fp;
endmodule

// File: rtl/vec_alu_stage.sv
module vec_alu_stage #(
  parameter int LANES = 16,
  parameter int LW    = vpu_pkg::LANE_W,
  parameter int DST_W = 5,
  localparam int BUS_W = LANES * LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [3:0]       in_op,
  input  logic [BUS_W-1:0] in_a,
  input  logic [BUS_W-1:0] in_b,
  input  logic             in_a_scalar,
  input  logic             in_b_scalar,
  input  logic             in_scalar_result,
  input  logic [LANES-1:0] in_pred,
  input  logic [DST_W-1:0] in_dst,
  output logic             out_valid,
  output logic [BUS_W-1:0] out_result,
  output logic [LANES-1:0] out_mask,
  output logic             out_fp_error,
  output logic [DST_W-1:0] out_dst
);
  logic [BUS_W-1:0] bcast_a;
  logic [BUS_W-1:0] bcast_b;
  logic [BUS_W-1:0] lane_raw;
  logic [BUS_W-1:0] lane_kept;
  logic [LANES-1:0] mask_next;
  logic             fp_err_next;
  logic             op_fp;

  assign op_fp = vpu_pkg::op_is_fp(in_op);

  vpu_operand_bcast #(.LANES(LANES), .LW(LW)) i_bcast_a (
    .bus_in(in_a), .use_scalar(in_a_scalar), .bus_out(bcast_a)
  );
  vpu_operand_bcast #(.LANES(LANES), .LW(LW)) i_bcast_b (
    .bus_in(in_b), .use_scalar(in_b_scalar), .bus_out(bcast_b)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lanes
    logic keep;
    vpu_lane i_lane (
      .op(in_op),
      .a (bcast_a[i*LW +: LW]),
      .b (bcast_b[i*LW +: LW]),
      .r (lane_raw[i*LW +: LW])
    );
    assign keep = in_valid && !op_fp && (!in_scalar_result || (i == 0));
    assign lane_kept[i*LW +: LW] = keep ? lane_raw[i*LW +: LW] : '0;
  end

  vpu_mask_gen #(.LANES(LANES)) i_mask (
    .valid(in_valid), .is_fp(op_fp), .scalar_result(in_scalar_result),
    .pred(in_pred), .mask(mask_next), .fp_error(fp_err_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_mask     <= '0;
      out_fp_error <= 1'b0;
      out_dst      <= '0;
    end else begin
      out_valid    <= in_valid;
      out_result   <= lane_kept;
      out_mask     <= mask_next;
      out_fp_error <= fp_err_next;
      out_dst      <= in_valid ? in_dst : '0;
    end
  end
endmodule

// File: rtl/vec_alu_stage_chk.sv
module vec_alu_stage_chk #(
  parameter int LANES = 16,
  parameter int LW    = 32,
  localparam int BUS_W = LANES * LW
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             op_fp,
  input logic             in_scalar_result,
  input logic [LANES-1:0] in_pred,
  input logic [LW-1:0]    in_a_lane0,
  input logic             in_a_scalar,
  input logic [BUS_W-1:0] bcast_a,
  input logic             out_valid,
  input logic [BUS_W-1:0] out_result,
  input logic [LANES-1:0] out_mask,
  input logic             out_fp_error
);
  localparam logic [LANES-1:0] LANE0_ONLY = LANES'(1);

  // R7: valid follows one cycle later
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r7_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R4: scalar result writes lane 0 only
  a_r4_scalar_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_fp && in_scalar_result) |=> (out_mask == LANE0_ONLY));

  // R5: vector result takes the predicate
  a_r5_pred_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_fp && !in_scalar_result) |=> (out_mask == $past(in_pred)));

  // R6: floating-point class is rejected
  a_r6_fp_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_fp) |=> (out_fp_error && out_mask == '0 && out_result == '0));

  // R8: idle output is quiet
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_mask == '0 && !out_fp_error && out_result == '0));

  // R1: broadcast reaches every lane
  for (genvar i = 0; i < LANES; i++) begin : g_bc
    a_r1_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
      in_a_scalar |-> (bcast_a[i*LW +: LW] == in_a_lane0));
  end
endmodule

bind vec_alu_stage vec_alu_stage_chk #(.LANES(LANES), .LW(LW)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_fp(op_fp),
  .in_scalar_result(in_scalar_result), .in_pred(in_pred),
  .in_a_lane0(in_a[LW-1:0]), .in_a_scalar(in_a_scalar), .bcast_a(bcast_a),
  .out_valid(out_valid), .out_result(out_result), .out_mask(out_mask),
  .out_fp_error(out_fp_error)
);

// File: tb/test_vec_alu_stage.sv
module test_vec_alu_stage;
  localparam int N  = 16;
  localparam int W  = 32;
  localparam int BW = N * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [3:0]    in_op = '0;
  logic [BW-1:0] in_a = '0, in_b = '0;
  logic          in_a_scalar = 1'b0, in_b_scalar = 1'b0, in_scalar_result = 1'b0;
  logic [N-1:0]  in_pred = '0;
  logic [4:0]    in_dst = '0;
  logic          out_valid, out_fp_error;
  logic [BW-1:0] out_result;
  logic [N-1:0]  out_mask;
  logic [4:0]    out_dst;

  int checks = 0;
  int errors = 0;

  logic          e_valid = 1'b0, e_err = 1'b0;
  logic [BW-1:0] e_result = '0;
  logic [N-1:0]  e_mask = '0;
  logic [4:0]    e_dst = '0;
  string         e_tag = "R10";

  always #5 clk = ~clk;

  vec_alu_stage i_vec_alu_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_a_scalar(in_a_scalar), .in_b_scalar(in_b_scalar),
    .in_scalar_result(in_scalar_result), .in_pred(in_pred), .in_dst(in_dst),
    .out_valid(out_valid), .out_result(out_result), .out_mask(out_mask),
    .out_fp_error(out_fp_error), .out_dst(out_dst)
  );

  // Reference arithmetic for one lane, from the requirement text (R2, R3)
  function automatic logic [31:0] ref_op(input int op, input logic [31:0] a, input logic [31:0] b);
    int sa, sb;
    sa = a; sb = b;
    if (op == 0) return a + b;
    if (op == 1) return a + (~b) + 32'd1;
    if (op == 2) return a & b;
    if (op == 3) return a | b;
    if (op == 4) return a ^ b;
    if (op == 5) return a << (b % 32);
    if (op == 6) return a >> (b % 32);
    if (op == 7) return (sa < sb) ? 32'd1 : 32'd0;
    return 32'd0;
  endfunction

  task automatic compare();
    checks++;
    if (out_valid !== e_valid) begin
      errors++;
      $display("FAIL R7 out_valid actual %0b expected %0b", out_valid, e_valid);
    end
    checks++;
    if (out_mask !== e_mask || out_fp_error !== e_err) begin
      errors++;
      $display("FAIL %s mask/err actual %h/%0b expected %h/%0b", e_tag, out_mask, out_fp_error, e_mask, e_err);
    end
    checks++;
    if (out_result !== e_result) begin
      errors++;
      $display("FAIL %s result actual %h expected %h", e_tag, out_result, e_result);
    end
    checks++;
    if (out_dst !== e_dst) begin
      errors++;
      $display("FAIL R9 dst actual %0d expected %0d", out_dst, e_dst);
    end
  endtask

  // At a falling edge: check the previous instruction, then present a new one
  task automatic step(input logic v, input int op, input logic [BW-1:0] a, input logic [BW-1:0] b,
                      input logic as, input logic bs, input logic sres,
                      input logic [N-1:0] pred, input logic [4:0] dst);
    @(negedge clk);
    compare();
    in_valid = v; in_op = 4'(op); in_a = a; in_b = b;
    in_a_scalar = as; in_b_scalar = bs; in_scalar_result = sres;
    in_pred = pred; in_dst = dst;
    e_valid = v;
    e_result = '0;
    e_err = 1'b0;
    e_mask = '0;
    e_dst = v ? dst : 5'd0;
    if (!v) e_tag = "R8";
    else if (op >= 8) begin
      e_tag = "R6";
      e_err = 1'b1;
    end else begin
      for (int i = 0; i < N; i++) begin
        logic [31:0] la, lb;
        la = as ? a[31:0] : a[i*W +: W];
        lb = bs ? b[31:0] : b[i*W +: W];
        if (!sres || i == 0) e_result[i*W +: W] = ref_op(op, la, lb);
      end
      e_mask = sres ? 16'h0001 : pred;
      if (sres) e_tag = "R4";
      else if (as || bs) e_tag = "R1";
      else if (op >= 5) e_tag = "R3";
      else e_tag = "R5";
    end
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [BW-1:0] a, b;
    repeat (3) @(posedge clk);
    // R10: outputs during reset
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    for (int pat = 0; pat < 4; pat++) begin
      for (int op = 0; op < 16; op++) begin
        for (int combo = 0; combo < 8; combo++) begin
          for (int i = 0; i < N; i++) begin
            case (pat)
              0: begin a[i*W +: W] = $urandom; b[i*W +: W] = $urandom; end
              1: begin a[i*W +: W] = 32'h7FFF_FFF8 + 32'(i); b[i*W +: W] = 32'h8000_0000 + 32'(i * 3); end
              2: begin a[i*W +: W] = 32'hA5C3_0001 ^ 32'(i << 9); b[i*W +: W] = 32'hFFFF_FFE0 | 32'(i * 2); end
              default: begin a[i*W +: W] = 32'(i) - 32'd8; b[i*W +: W] = 32'd8 - 32'(i); end
            endcase
          end
          step(1'b1, op, a, b, combo[0], combo[1], combo[2], 16'($urandom), 5'($urandom));
          if (((op + combo) % 7) == 3)
            step(1'b0, 0, a, b, 1'b0, 1'b0, 1'b0, 16'hFFFF, 5'd31); // R8 idle bubble
        end
      end
    end
    // R5: all-ones and all-zero predicates; R3: shift by 31 with high bits set
    for (int i = 0; i < N; i++) begin a[i*W +: W] = 32'h8000_0001; b[i*W +: W] = 32'hFFFF_FFFF; end
    step(1'b1, 5, a, b, 1'b0, 1'b0, 1'b0, 16'hFFFF, 5'd7);
    step(1'b1, 6, a, b, 1'b0, 1'b0, 1'b0, 16'h0000, 5'd9);
    step(1'b1, 7, a, b, 1'b0, 1'b1, 1'b1, 16'h0000, 5'd1);
    step(1'b0, 0, a, b, 1'b0, 1'b0, 1'b0, 16'h0000, 5'd0);
    step(1'b0, 0, a, b, 1'b0, 1'b0, 1'b0, 16'h0000, 5'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule